// File: doc/BRIEF.md
# Prioritized Interrupt Arbiter for a Small Microcontroller Core

This block sits beside the execution core of a small 8-bit microcontroller and decides when an interrupt is taken. It watches four event sources: an edge on an external pin, an overflow from timer 0, an overflow from timer 1, and a completion pulse from the analog-to-digital converter. Timer 1 exists only when the `TWO_TIMERS` parameter is set. Each event latches a pending flag. Software owns a per-source enable mask and a global enable bit. When the core reports an instruction boundary, the arbiter checks for a pending, enabled source. If one exists, the global enable is set and the return stack has room, it raises `take` for that cycle and drives the vector address of the winning source. The core then pushes its own next-instruction address and jumps to that vector.

Taking an interrupt clears the global enable. Further interrupts are therefore blocked until software sets the bit again (nesting) or the routine returns. Events that arrive while interrupts are blocked are still latched and wait their turn. The arbiter keeps a count of return-stack occupancy from the core's push and pop strobes. It will not grant while that count is at its limit. A return-from-interrupt strobe pops one level and sets the global enable again.

Top module: `irq_arbiter`

## Requirements
- R1: A one-cycle pulse on `tmr0_ovf`, `tmr1_ovf` or `adc_done` sets `flag_q` bit 1, 2 or 3 at the next clock edge. The bit stays set whatever the enables are, until it is granted or software clears it.
- R2: `ext_pin` passes through a two-flop synchronizer. A change of `ext_pin` made between clock edges sets `flag_q` bit 0 on the third following edge. The change must be a rising one when `edge_rise`=1 and a falling one when `edge_rise`=0; the other direction sets nothing.
- R3: `take` is high exactly when `can_take`, `gie_q` and at least one bit of `flag_q & en_q` are all high and `stack_full` is low.
- R4: Among the pending enabled sources, the lowest bit index wins. Bit 0 is external, bit 1 is timer 0, bit 2 is timer 1 and bit 3 is the converter. While `take` is high, `vec_addr` equals (index+1)*4: 0x04, 0x08, 0x0C or 0x10.
- R5: On a clock edge where `take` is high, the winning flag is cleared, the other flags are kept, `gie_q` goes low and `stack_level` rises by one.
- R6: While `gie_q` is low, no grant occurs and flags keep accumulating. Once software sets `gie_q` again, the held requests are granted.
- R7: `stack_full` is high when `stack_level` equals `STACK_DEPTH`, and no grant occurs then. A `call_pop` lowers the level and grants are allowed again.
- R8: A `reti` strobe lowers `stack_level` by one and sets `gie_q` at the next edge.
- R9: `flag_we` overwrites all flags with `flag_wdata`. An event on the same cycle still sets its bit. `en_we` and `gie_we` load `en_q` and `gie_q`.
- R10: With `TWO_TIMERS`=0, bit 2 of `flag_q` and `en_q` always reads 0 and `tmr1_ovf` has no effect. The converter still uses vector 0x10.
- R11: After reset, `flag_q`, `en_q`, `gie_q`, `stack_level` and `take` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| edge_rise | input | 1 | 1: rising edge active, 0: falling edge active |
| tmr0_ovf | input | 1 | Timer 0 overflow pulse |
| tmr1_ovf | input | 1 | Timer 1 overflow pulse (ignored without second timer) |
| adc_done | input | 1 | Converter completion pulse |
| en_we | input | 1 | Write strobe for the enable mask |
| en_wdata | input | 4 | New enable mask |
| flag_we | input | 1 | Write strobe for the pending flags |
| flag_wdata | input | 4 | New pending flags |
| gie_we | input | 1 | Write strobe for the global enable |
| gie_wdata | input | 1 | New global enable |
| can_take | input | 1 | Core is at an instruction boundary |
| call_push | input | 1 | Core pushed a subroutine return address |
| call_pop | input | 1 | Core popped a subroutine return address |
| reti | input | 1 | Core executed a return from interrupt |
| take | output | 1 | Grant: core pushes its address and jumps to `vec_addr` |
| vec_addr | output | PC_W | Vector address of the winning source |
| en_q | output | 4 | Current enable mask |
| flag_q | output | 4 | Current pending flags |
| gie_q | output | 1 | Current global enable |
| stack_full | output | 1 | Return stack at its limit |
| stack_level | output | LVL_W | Return stack occupancy |

## Verification
Some rules are checked by assertions on every cycle. A grant never occurs without the global enable, a pending enabled flag, a boundary and stack room. Each grant drops the global enable and adds one stack level. A return sets the global enable. The level never passes the depth, and each vector is a non-zero multiple of four.

Other behaviour can only be shown by the bench's scenarios. These include the winner and vector over the full sweep of flag and enable patterns, and the exact synchronizer latency in both edge modes. They also include requests held while blocked and granted after software re-enables, stack-full hold-off released by a pop, and the missing timer in the small configuration.

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter bit TWO_TIMERS  = 1'b1,
  parameter int PC_W        = 11,
  parameter int STACK_DEPTH = 6,
  parameter int VEC_STEP    = 4,
  localparam int LVL_W      = $clog2(STACK_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_pin,
  input  logic             edge_rise,
  input  logic             tmr0_ovf,
  input  logic             tmr1_ovf,
  input  logic             adc_done,
  input  logic             en_we,
  input  logic [3:0]       en_wdata,
  input  logic             flag_we,
  input  logic [3:0]       flag_wdata,
  input  logic             gie_we,
  input  logic             gie_wdata,
  input  logic             can_take,
  input  logic             call_push,
  input  logic             call_pop,
  input  logic             reti,
  output logic             take,
  output logic [PC_W-1:0]  vec_addr,
  output logic [3:0]       en_q,
  output logic [3:0]       flag_q,
  output logic             gie_q,
  output logic             stack_full,
  output logic [LVL_W-1:0] stack_level
);
  localparam logic [3:0] PRESENT = TWO_TIMERS ? 4'b1111 : 4'b1011;

  logic       s1, s2, s3;
  logic       ext_evt;
  logic [3:0] events, ready, grant;
  logic [1:0] idx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s1, s2, s3} <= 3'b000;
    else        {s1, s2, s3} <= {ext_pin, s1, s2};

  assign ext_evt = edge_rise ? (s2 & ~s3) : (~s2 & s3);
  assign events  = {adc_done, tmr1_ovf, tmr0_ovf, ext_evt} & PRESENT;
  assign ready   = flag_q & en_q;

  always_comb begin
    idx = 2'd0;
    for (int i = 3; i >= 0; i--)
      if (ready[i]) idx = 2'(i);
  end

  assign stack_full = (stack_level == LVL_W'(STACK_DEPTH));
  assign take       = can_take & gie_q & (|ready) & ~stack_full;
  assign grant      = take ? (4'b0001 << idx) : 4'b0000;
  assign vec_addr   = PC_W'((32'(idx) + 32'd1) * VEC_STEP);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flag_q <= 4'b0000;
      en_q   <= 4'b0000;
    end else begin
      flag_q <= ((flag_we ? flag_wdata : (flag_q & ~grant)) | events) & PRESENT;
      if (en_we) en_q <= en_wdata & PRESENT;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      gie_q <= 1'b0;
    else if (take)   gie_q <= 1'b0;
    else if (gie_we) gie_q <= gie_wdata;
    else if (reti)   gie_q <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) stack_level <= '0;
    else        stack_level <= stack_level + LVL_W'(take) + LVL_W'(call_push)
                             - LVL_W'(call_pop) - LVL_W'(reti);
endmodule

// File: rtl/irq_arbiter_props.sv
module irq_arbiter_props #(
  parameter int PC_W        = 11,
  parameter int STACK_DEPTH = 6,
  parameter int VEC_STEP    = 4,
  parameter int LVL_W       = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             take,
  input logic             can_take,
  input logic             gie_q,
  input logic             gie_we,
  input logic             reti,
  input logic             call_push,
  input logic             call_pop,
  input logic [3:0]       flag_q,
  input logic [3:0]       en_q,
  input logic             stack_full,
  input logic [LVL_W-1:0] stack_level,
  input logic [PC_W-1:0]  vec_addr
);
  assert_ack_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (can_take && gie_q && ((flag_q & en_q) != 4'b0000) && !stack_full));

  assert_no_ack_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stack_full |-> !take);

  assert_level_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stack_level <= LVL_W'(STACK_DEPTH));

  assert_gie_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !gie_q);

  assert_level_bump_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !call_push && !call_pop && !reti) |=> stack_level == $past(stack_level) + LVL_W'(1));

  assert_reti_gie_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !take && !gie_we) |=> gie_q);

  assert_vec_grid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (vec_addr != '0 && (int'(vec_addr) % VEC_STEP) == 0 && int'(vec_addr) <= 4 * VEC_STEP));
endmodule

bind irq_arbiter irq_arbiter_props #(
  .PC_W(PC_W), .STACK_DEPTH(STACK_DEPTH), .VEC_STEP(VEC_STEP), .LVL_W(LVL_W)
) u_props (
  .clk(clk), .rst_n(rst_n), .take(take), .can_take(can_take), .gie_q(gie_q),
  .gie_we(gie_we), .reti(reti), .call_push(call_push), .call_pop(call_pop),
  .flag_q(flag_q), .en_q(en_q), .stack_full(stack_full),
  .stack_level(stack_level), .vec_addr(vec_addr)
);

// File: tb/sim_irq_arbiter.sv
module sim_irq_arbiter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ext_pin = 0, edge_rise = 1, tmr0_ovf = 0, tmr1_ovf = 0, adc_done = 0;
  logic en_we = 0, flag_we = 0, gie_we = 0, gie_wdata = 0;
  logic [3:0] en_wdata = 0, flag_wdata = 0;
  logic can_take = 0, call_push = 0, call_pop = 0, reti = 0;

  logic take0, take1, gie0, gie1, full0, full1;
  logic [10:0] vec0, vec1;
  logic [3:0] en0, en1, fl0, fl1;
  logic [2:0] lvl0;
  logic [2:0] lvl1;

  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_arbiter #(.TWO_TIMERS(1'b1), .PC_W(11), .STACK_DEPTH(4)) u0 (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .edge_rise(edge_rise),
    .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf), .adc_done(adc_done),
    .en_we(en_we), .en_wdata(en_wdata), .flag_we(flag_we), .flag_wdata(flag_wdata),
    .gie_we(gie_we), .gie_wdata(gie_wdata), .can_take(can_take),
    .call_push(call_push), .call_pop(call_pop), .reti(reti),
    .take(take0), .vec_addr(vec0), .en_q(en0), .flag_q(fl0), .gie_q(gie0),
    .stack_full(full0), .stack_level(lvl0));

  irq_arbiter #(.TWO_TIMERS(1'b0), .PC_W(11), .STACK_DEPTH(4)) u1 (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .edge_rise(edge_rise),
    .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf), .adc_done(adc_done),
    .en_we(en_we), .en_wdata(en_wdata), .flag_we(flag_we), .flag_wdata(flag_wdata),
    .gie_we(gie_we), .gie_wdata(gie_wdata), .can_take(can_take),
    .call_push(call_push), .call_pop(call_pop), .reti(reti),
    .take(take1), .vec_addr(vec1), .en_q(en1), .flag_q(fl1), .gie_q(gie1),
    .stack_full(full1), .stack_level(lvl1));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic setregs(input logic [3:0] e, input logic [3:0] f, input logic g);
    @(negedge clk);
    en_we = 1; en_wdata = e; flag_we = 1; flag_wdata = f; gie_we = 1; gie_wdata = g;
    @(negedge clk);
    en_we = 0; flag_we = 0; gie_we = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 flags", fl0, 0); chk("R11 enables", en0, 0); chk("R11 gie", gie0, 0);
    chk("R11 level", lvl0, 0); chk("R11 take", take0, 0);
    rst_n = 1;

    // R10 small configuration lacks timer 1
    setregs(4'hF, 4'hF, 1'b0);
    chk("R10 en bit2 absent", en1, 4'hB); chk("R10 flag bit2 absent", fl1, 4'hB);
    setregs(4'hF, 4'h0, 1'b0);
    @(negedge clk) tmr1_ovf = 1;
    @(negedge clk) tmr1_ovf = 0;
    chk("R10 tmr1 ignored", fl1, 0);
    chk("R1 tmr1 sets flag", fl0, 4'h4);
    setregs(4'hF, 4'h8, 1'b1);
    can_take = 1; #1;
    chk("R10 adc take", take1, 1); chk("R10 adc vector", vec1, 16);
    can_take = 0;

    // R4/R3/R9 sweep of every flag and enable pattern
    for (int e = 0; e < 16; e++)
      for (int f = 0; f < 16; f++) begin
        int rdy, exp_idx;
        setregs(4'(e), 4'(f), 1'b1);
        chk("R9 flag write", fl0, f); chk("R9 enable write", en0, e);
        rdy = e & f;
        exp_idx = 0;
        for (int i = 3; i >= 0; i--) if (rdy[i]) exp_idx = i;
        can_take = 1; #1;
        chk("R3 grant condition", take0, int'(rdy != 0));
        if (rdy != 0) chk("R4 priority vector", vec0, (exp_idx + 1) * 4);
        can_take = 0;
      end

    // R5 grant effects
    setregs(4'hF, 4'hF, 1'b1);
    can_take = 1; #1;
    chk("R5 take", take0, 1); chk("R4 ext vector", vec0, 4);
    @(negedge clk) can_take = 0;
    chk("R5 flag cleared", fl0, 4'hE); chk("R5 gie cleared", gie0, 0); chk("R5 level", lvl0, 1);

    // R1/R6 events held while blocked, then nested
    setregs(4'hF, 4'h0, 1'b0);
    @(negedge clk) begin tmr0_ovf = 1; adc_done = 1; end
    @(negedge clk) begin tmr0_ovf = 0; adc_done = 0; end
    chk("R1 flags latched", fl0, 4'hA);
    can_take = 1; gie_we = 1; gie_wdata = 1; #1;
    chk("R6 blocked", take0, 0);
    @(negedge clk) gie_we = 0; #1;
    chk("R6 held request granted", take0, 1); chk("R4 timer0 vector", vec0, 8);
    @(negedge clk) can_take = 0;
    chk("R6 level after nest", lvl0, 2); chk("R5 other flag kept", fl0, 4'h8);
    reti = 1;
    @(negedge clk) reti = 0;
    chk("R8 level", lvl0, 1); chk("R8 gie set", gie0, 1);
    can_take = 1; #1;
    chk("R4 adc vector", vec0, 16); chk("R8 take after reti", take0, 1);
    @(negedge clk) can_take = 0;
    chk("R5 level", lvl0, 2); chk("R5 adc cleared", fl0, 0);

    // R7 full stack holds off grants
    setregs(4'hF, 4'h1, 1'b1);
    call_push = 1;
    repeat (2) @(negedge clk);
    call_push = 0;
    chk("R7 level at depth", lvl0, 4); chk("R7 full", full0, 1);
    can_take = 1; #1;
    chk("R7 no grant when full", take0, 0);
    @(negedge clk) call_pop = 1;
    @(negedge clk) call_pop = 0; #1;
    chk("R7 level after pop", lvl0, 3); chk("R7 not full", full0, 0);
    chk("R7 grant after pop", take0, 1);
    @(negedge clk) can_take = 0;
    chk("R7 level after grant", lvl0, 4);

    // R9 software write and event on same cycle
    @(negedge clk) begin flag_we = 1; flag_wdata = 4'h0; tmr0_ovf = 1; end
    @(negedge clk) begin flag_we = 0; tmr0_ovf = 0; end
    chk("R9 event wins over write", fl0, 4'h2);

    // R2 external edge, rising mode
    setregs(4'h0, 4'h0, 1'b0);
    edge_rise = 1; ext_pin = 1;
    @(negedge clk) chk("R2 rise edge1", fl0, 0);
    @(negedge clk) chk("R2 rise edge2", fl0, 0);
    @(negedge clk) chk("R2 rise edge3", fl0, 1);
    setregs(4'h0, 4'h0, 1'b0);
    edge_rise = 0;
    repeat (3) @(negedge clk);
    ext_pin = 0;
    @(negedge clk) chk("R2 fall edge1", fl0, 0);
    @(negedge clk) chk("R2 fall edge2", fl0, 0);
    @(negedge clk) chk("R2 fall edge3", fl0, 1);
    setregs(4'h0, 4'h0, 1'b0);
    ext_pin = 1;
    repeat (5) @(negedge clk);
    chk("R2 rise ignored in fall mode", fl0, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule